// File: doc/BRIEF.md
# Packed-BCD Calendar Clock with Keyed Write Protection

This block keeps wall-clock time and date as packed BCD fields: seconds, minutes, hours, day of month, month and a two-digit year. A free-running prescaler counts enable pulses from a 32 kHz source. Each time it completes `PRESCALE` enabled pulses it advances the calendar by one second. Carries ripple through minutes, hours, days (with month lengths and leap Februaries), months and years.

Software reaches the block over a small word-addressed register bus. Reads are combinational and always permitted. Writes to the time fields, the run control and the oscillator enable take effect only after a two-step key sequence has opened the lock. A status bit marks a short busy window that ends with each one-second update. Time-field writes that arrive inside that window are dropped, so an update can never tear a freshly written value.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset all six time fields read 0x00, the run bit (address 6, bit 0) reads 0, the oscillator-enable bit (address 8, bit 0) reads 0, the busy bit (address 7, bit 0) reads 0, and the lock is closed.
- R2: Time writes store only the field width. Seconds (address 0) and minutes (address 1) keep 7 bits, hours (2) and day (3) keep 6 bits, month (4) keeps 5 bits and year (5) keeps 8 bits. The run and oscillator registers keep bit 0 only.
- R3: The lock opens only when `KEY0` is written to address 9 and then `KEY1` is written to address 10. Writing `KEY1` while the lock is closed leaves it closed. Writing `KEY0` always leaves the lock armed but not yet open.
- R4: Writing any value other than its key to address 9 or 10 closes the lock.
- R5: Writes to addresses 0–6 and 8 while the lock is not open change nothing. Reads of every address work in any lock state.
- R6: The calendar advances one second after every `PRESCALE` cycles in which `clk32_en`, the run bit and the oscillator bit are all 1. If any of the three is 0, time and prescaler hold.
- R7: Seconds and minutes wrap from 0x59 to 0x00 and carry. Hours wrap from 0x23 to 0x00 and carry.
- R8: The day wraps to 0x01 after the last day of its month, with 30 days for months 0x04, 0x06, 0x09 and 0x11 and 31 days for the others except February. The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00.
- R9: February (0x02) has 29 days when the two-digit year is divisible by 4, and 28 days otherwise.
- R10: The busy bit (address 7, bit 0) reads 1 exactly while the prescaler is in its last `BUSY_LEN` counts, which include the update cycle. A time-field write accepted by the lock but arriving while busy is 1 is dropped.
- R11: The revision register (address 11) returns `REV_MAJOR` in bits [10:8], `REV_MINOR` in bits [4:0], and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk32_en | input | 1 | One-cycle enable pulse from the 32 kHz source |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |

## Verification
The assertions assume that software writes only legal BCD values within each field's range. They also assume that writes to the run and oscillator registers are the only way counting starts or stops. The stimulus keeps to this outside the masking test, where out-of-range values are stored while the clock is paused and then overwritten before counting resumes. It also pauses the clock only directly after a one-second update, so the prescaler is parked outside the busy window before new time is loaded.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int REG_SEC    = 0;
    localparam int REG_MIN    = 1;
    localparam int REG_HOUR   = 2;
    localparam int REG_DAY    = 3;
    localparam int REG_MONTH  = 4;
    localparam int REG_YEAR   = 5;
    localparam int REG_RUN    = 6;
    localparam int REG_STATUS = 7;
    localparam int REG_OSC    = 8;
    localparam int REG_KEY0   = 9;
    localparam int REG_KEY1   = 10;
    localparam int REG_REV    = 11;

    typedef struct packed {
        logic [7:0] yr;
        logic [4:0] mon;
        logic [5:0] day;
        logic [5:0] hr;
        logic [6:0] min;
        logic [6:0] sec;
    } cal_t;

    typedef enum logic [1:0] {
        KEY_SHUT  = 2'd0,
        KEY_ARMED = 2'd1,
        KEY_OPEN  = 2'd2
    } key_state_e;

    // {carry, next}: wraps to 'first' once 'last' is reached
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v >= last)
            return {1'b1, first};
        if (v[3:0] >= 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6
    function automatic logic leap_year(input logic [7:0] y);
        if (y[4] == 1'b0)
            return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic logic [7:0] month_last_day(input logic [4:0] m,
                                                  input logic [7:0] y);
        case ({3'b000, m})
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 32768,
    parameter int BUSY_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    output logic sec_pulse,
    output logic busy
);
    localparam int CNT_W     = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam int LAST      = PRESCALE - 1;
    localparam int BUSY_FROM = PRESCALE - BUSY_LEN;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (count_en)
            cnt_d = (cnt_q == CNT_W'(LAST)) ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign sec_pulse = count_en && (cnt_q == CNT_W'(LAST));
    assign busy      = (cnt_q >= CNT_W'(BUSY_FROM));

endmodule

// File: rtl/rtc_keylock.sv
module rtc_keylock
    import rtc_pkg::*;
#(
    parameter int                 DATA_W = 32,
    parameter logic [DATA_W-1:0]  KEY0   = '0,
    parameter logic [DATA_W-1:0]  KEY1   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key0_wr,
    input  logic              key1_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              open
);
    key_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (key0_wr)
            st_d = (wdata == KEY0) ? KEY_ARMED : KEY_SHUT;
        else if (key1_wr)
            st_d = (wdata == KEY1 && st_q != KEY_SHUT) ? KEY_OPEN : KEY_SHUT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= KEY_SHUT;
        else        st_q <= st_d;
    end

    assign open = (st_q == KEY_OPEN);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       wr_en,
    input  logic [2:0] wr_field,
    input  logic [7:0] wr_val,
    output cal_t       cal
);
    cal_t cal_d, cal_q;
    logic [8:0] s_st, m_st, h_st, d_st, mo_st, y_st;

    always_comb begin
        cal_d = cal_q;
        s_st  = bcd_step({1'b0, cal_q.sec}, 8'h59, 8'h00);
        m_st  = bcd_step({1'b0, cal_q.min}, 8'h59, 8'h00);
        h_st  = bcd_step({2'b00, cal_q.hr}, 8'h23, 8'h00);
        d_st  = bcd_step({2'b00, cal_q.day},
                         month_last_day(cal_q.mon, cal_q.yr), 8'h01);
        mo_st = bcd_step({3'b000, cal_q.mon}, 8'h12, 8'h01);
        y_st  = bcd_step(cal_q.yr, 8'h99, 8'h00);
        if (wr_en) begin
            case (wr_field)
                3'd0:    cal_d.sec = wr_val[6:0];
                3'd1:    cal_d.min = wr_val[6:0];
                3'd2:    cal_d.hr  = wr_val[5:0];
                3'd3:    cal_d.day = wr_val[5:0];
                3'd4:    cal_d.mon = wr_val[4:0];
                3'd5:    cal_d.yr  = wr_val;
                default: ;
            endcase
        end else if (adv) begin
            cal_d.sec = s_st[6:0];
            if (s_st[8]) begin
                cal_d.min = m_st[6:0];
                if (m_st[8]) begin
                    cal_d.hr = h_st[5:0];
                    if (h_st[8]) begin
                        cal_d.day = d_st[5:0];
                        if (d_st[8]) begin
                            cal_d.mon = mo_st[4:0];
                            if (mo_st[8])
                                cal_d.yr = y_st[7:0];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= '0;
        else        cal_q <= cal_d;
    end

    assign cal = cal_q;

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int                PRESCALE  = 32768,
    parameter int                BUSY_LEN  = 4,
    parameter int                ADDR_W    = 4,
    parameter int                DATA_W    = 32,
    parameter logic [DATA_W-1:0] KEY0      = 32'h5AC3_0F91,
    parameter logic [DATA_W-1:0] KEY1      = 32'hE71B_6D24,
    parameter logic [2:0]        REV_MAJOR = 3'd2,
    parameter logic [4:0]        REV_MINOR = 5'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk32_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    typedef struct packed {
        logic run;
        logic osc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    cal_t cal_now;
    logic lock_open, busy, sec_pulse, count_en;
    logic time_addr, time_wr, key0_wr, key1_wr;
    int   addr_i;

    assign addr_i    = int'(bus_addr);
    assign time_addr = (addr_i <= REG_YEAR);
    assign key0_wr   = bus_wr && (addr_i == REG_KEY0);
    assign key1_wr   = bus_wr && (addr_i == REG_KEY1);
    assign time_wr   = bus_wr && lock_open && time_addr && !busy;
    assign count_en  = clk32_en && ctl_q.run && ctl_q.osc;

    rtc_keylock #(.DATA_W(DATA_W), .KEY0(KEY0), .KEY1(KEY1)) u_lock (
        .clk(clk), .rst_n(rst_n), .key0_wr(key0_wr), .key1_wr(key1_wr),
        .wdata(bus_wdata), .open(lock_open)
    );

    rtc_prescaler #(.PRESCALE(PRESCALE), .BUSY_LEN(BUSY_LEN)) u_presc (
        .clk(clk), .rst_n(rst_n), .count_en(count_en),
        .sec_pulse(sec_pulse), .busy(busy)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .adv(sec_pulse), .wr_en(time_wr),
        .wr_field(bus_addr[2:0]), .wr_val(bus_wdata[7:0]), .cal(cal_now)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr && lock_open) begin
            if (addr_i == REG_RUN) ctl_d.run = bus_wdata[0];
            if (addr_i == REG_OSC) ctl_d.osc = bus_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (addr_i)
            REG_SEC:    bus_rdata = DATA_W'(cal_now.sec);
            REG_MIN:    bus_rdata = DATA_W'(cal_now.min);
            REG_HOUR:   bus_rdata = DATA_W'(cal_now.hr);
            REG_DAY:    bus_rdata = DATA_W'(cal_now.day);
            REG_MONTH:  bus_rdata = DATA_W'(cal_now.mon);
            REG_YEAR:   bus_rdata = DATA_W'(cal_now.yr);
            REG_RUN:    bus_rdata = DATA_W'(ctl_q.run);
            REG_STATUS: bus_rdata = DATA_W'(busy);
            REG_OSC:    bus_rdata = DATA_W'(ctl_q.osc);
            REG_REV:    bus_rdata = DATA_W'({REV_MAJOR, 3'b000, REV_MINOR});
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_pkg::*;
#(
    parameter int                ADDR_W = 4,
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY0   = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              lock_open,
    input logic              busy,
    input logic              sec_pulse,
    input logic              run,
    input logic              osc,
    input cal_t              cal
);
    logic to_time;
    assign to_time = bus_wr && (int'(bus_addr) <= REG_YEAR);

    assert_open_needs_key1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_open) |-> $past(bus_wr && int'(bus_addr) == REG_KEY1));

    assert_wrong_key_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == REG_KEY0 && bus_wdata != KEY0) |=> !lock_open);

    assert_locked_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (to_time && !lock_open && !sec_pulse) |=> $stable(cal));

    assert_paused_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && osc) && !bus_wr) |=> $stable(cal));

    assert_sec_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && cal.sec == 7'h59) |=> (cal.sec == 7'h00));

    assert_update_inside_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |-> busy);

    assert_busy_write_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (to_time && busy && !sec_pulse) |=> $stable(cal));

endmodule

bind bcd_rtc_core rtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY0(KEY0)) u_rtc_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .lock_open(lock_open), .busy(busy),
    .sec_pulse(sec_pulse), .run(ctl_q.run), .osc(ctl_q.osc), .cal(cal_now)
);

// File: tb/bcd_rtc_core_bench.sv
`timescale 1ns/1ps
module bcd_rtc_core_bench;
    localparam int          P  = 8;
    localparam int          BL = 2;
    localparam logic [31:0] K0 = 32'h5AC3_0F91;
    localparam logic [31:0] K1 = 32'hE71B_6D24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk32_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    always #2.5 clk = ~clk;

    bcd_rtc_core #(.PRESCALE(P), .BUSY_LEN(BL), .KEY0(K0), .KEY1(K1),
                   .REV_MAJOR(3'd2), .REV_MINOR(5'd1)) u_bcd_rtc_core (
        .clk(clk), .rst_n(rst_n), .clk32_en(clk32_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    bit tick_on = 0;
    int rot = 0;

    // reference state: raw register values, prescaler count, lock 0/1/2
    int m_f[6];
    int m_run = 0, m_osc = 0, m_cnt = 0, m_lock = 0;

    function automatic int b2i(int v); return (v >> 4) * 10 + (v & 15); endfunction
    function automatic int i2b(int n); return ((n / 10) << 4) | (n % 10); endfunction

    function automatic int mdays(int mon_bcd, int yr_bcd);
        int m = b2i(mon_bcd);
        if (m == 2) return (b2i(yr_bcd) % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic logic [31:0] exp_read(int a);
        if (a <= 5) return 32'(m_f[a]);
        if (a == 6) return 32'(m_run);
        if (a == 7) return (m_cnt >= P - BL) ? 32'd1 : 32'd0;
        if (a == 8) return 32'(m_osc);
        if (a == 11) return 32'h0000_0201;
        return 32'd0;
    endfunction

    task automatic advance_second();
        int s = b2i(m_f[0]), mi = b2i(m_f[1]), h = b2i(m_f[2]);
        int d = b2i(m_f[3]), mo = b2i(m_f[4]), y = b2i(m_f[5]);
        int dim = mdays(m_f[4], m_f[5]);
        if (s < 59) begin m_f[0] = i2b(s + 1); return; end
        m_f[0] = 0;
        if (mi < 59) begin m_f[1] = i2b(mi + 1); return; end
        m_f[1] = 0;
        if (h < 23) begin m_f[2] = i2b(h + 1); return; end
        m_f[2] = 0;
        if (d < dim) begin m_f[3] = i2b(d + 1); return; end
        m_f[3] = 1;
        if (mo < 12) begin m_f[4] = i2b(mo + 1); return; end
        m_f[4] = 1;
        m_f[5] = (y < 99) ? i2b(y + 1) : 0;
    endtask

    task automatic model_step(bit wr, int a, logic [31:0] d, bit tk);
        bit busy_old = (m_cnt >= P - BL);
        bit open_old = (m_lock == 2);
        bit en = tk && m_run == 1 && m_osc == 1;
        int run_old = m_run, osc_old = m_osc;
        if (wr && a == 9)  m_lock = (d == K0) ? 1 : 0;
        if (wr && a == 10) m_lock = (d == K1 && m_lock != 0) ? 2 : 0;
        if (wr && open_old) begin
            if (a <= 5 && !busy_old) begin
                case (a)
                    0, 1: m_f[a] = int'(d & 32'h7F);
                    2, 3: m_f[a] = int'(d & 32'h3F);
                    4:    m_f[a] = int'(d & 32'h1F);
                    default: m_f[a] = int'(d & 32'hFF);
                endcase
            end
            if (a == 6) m_run = int'(d[0]);
            if (a == 8) m_osc = int'(d[0]);
        end
        if (en) begin
            if (m_cnt == P - 1) begin m_cnt = 0; advance_second(); end
            else m_cnt = m_cnt + 1;
        end
        if (run_old < 0 || osc_old < 0) m_cnt = 0;
    endtask

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    // one bus cycle, compared against the model after the edge
    task automatic cyc(bit wr, int a, logic [31:0] d, string req);
        bus_wr = wr; bus_addr = 4'(a); bus_wdata = d; clk32_en = tick_on;
        @(posedge clk);
        model_step(wr, a, d, tick_on);
        @(negedge clk);
        check(req, bus_rdata, exp_read(a));
        bus_wr = 1'b0;
    endtask

    task automatic wr_reg(int a, logic [31:0] d, string req);
        cyc(1'b1, a, d, req);
    endtask

    task automatic rd_reg(int a, string req);
        cyc(1'b0, a, 32'd0, req);
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) begin
            rd_reg((rot == 9) ? 11 : rot, req);
            rot = (rot + 1) % 10;
        end
    endtask

    task automatic unlock(string req);
        wr_reg(9, K0, req);
        wr_reg(10, K1, req);
    endtask

    // stop just after an update so the prescaler rests outside the busy window
    task automatic pause_safe(string req);
        if (m_run == 1 && m_osc == 1 && tick_on) begin
            rd_reg(7, req);
            while (bus_rdata[0] !== 1'b1) rd_reg(7, req);
            while (bus_rdata[0] !== 1'b0) rd_reg(7, req);
        end
        wr_reg(6, 32'd0, req);
    endtask

    task automatic load(int s, int mi, int h, int d, int mo, int y, string req);
        pause_safe(req);
        wr_reg(0, 32'(s), req);  wr_reg(1, 32'(mi), req); wr_reg(2, 32'(h), req);
        wr_reg(3, 32'(d), req);  wr_reg(4, 32'(mo), req); wr_reg(5, 32'(y), req);
        wr_reg(8, 32'd1, req);
        wr_reg(6, 32'd1, req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R6 actual hang expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m_f[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state over every register
        idle(10, "R1");
        rd_reg(11, "R11");
        check("R11", bus_rdata, 32'h0000_0201);

        // R5 locked writes, R3 order of keys
        wr_reg(0, 32'h30, "R5");
        rd_reg(0, "R5"); check("R5", bus_rdata, 32'h00);
        wr_reg(10, K1, "R3");
        wr_reg(0, 32'h30, "R3");
        rd_reg(0, "R3"); check("R3", bus_rdata, 32'h00);
        wr_reg(9, K0, "R3");
        wr_reg(0, 32'h30, "R3");
        rd_reg(0, "R3"); check("R3", bus_rdata, 32'h00);
        wr_reg(10, K1, "R3");
        wr_reg(0, 32'h30, "R3");
        rd_reg(0, "R3"); check("R3", bus_rdata, 32'h30);

        // R4 wrong values close the lock
        wr_reg(10, 32'h1, "R4");
        wr_reg(0, 32'h45, "R4");
        rd_reg(0, "R4"); check("R4", bus_rdata, 32'h30);
        unlock("R4");
        wr_reg(9, 32'h0, "R4");
        wr_reg(6, 32'h1, "R4");
        rd_reg(6, "R4"); check("R4", bus_rdata, 32'h0);
        unlock("R4");

        // R2 field masking
        for (int a = 0; a < 6; a++) wr_reg(a, 32'hFFFF_FFFF, "R2");
        rd_reg(0, "R2"); check("R2", bus_rdata, 32'h7F);
        rd_reg(2, "R2"); check("R2", bus_rdata, 32'h3F);
        rd_reg(4, "R2"); check("R2", bus_rdata, 32'h1F);
        rd_reg(5, "R2"); check("R2", bus_rdata, 32'hFF);
        wr_reg(8, 32'hFFFF_FFFE, "R2");
        rd_reg(8, "R2"); check("R2", bus_rdata, 32'h0);

        // R7 R8 non-leap February into March
        tick_on = 1;
        load(32'h50, 32'h59, 32'h23, 32'h28, 32'h02, 32'h23, "R7");
        idle(12 * P, "R7");
        rd_reg(3, "R8"); check("R8", bus_rdata, 32'h01);
        rd_reg(4, "R8"); check("R8", bus_rdata, 32'h03);
        rd_reg(2, "R7"); check("R7", bus_rdata, 32'h00);

        // R9 leap February
        load(32'h58, 32'h59, 32'h23, 32'h28, 32'h02, 32'h24, "R9");
        idle(4 * P, "R9");
        rd_reg(3, "R9"); check("R9", bus_rdata, 32'h29);
        load(32'h58, 32'h59, 32'h23, 32'h29, 32'h02, 32'h24, "R9");
        idle(4 * P, "R9");
        rd_reg(3, "R9"); check("R9", bus_rdata, 32'h01);
        rd_reg(4, "R9"); check("R9", bus_rdata, 32'h03);

        // R8 thirty-day month and year wrap
        load(32'h58, 32'h59, 32'h23, 32'h30, 32'h04, 32'h10, "R8");
        idle(4 * P, "R8");
        rd_reg(4, "R8"); check("R8", bus_rdata, 32'h05);
        load(32'h58, 32'h59, 32'h23, 32'h31, 32'h12, 32'h99, "R8");
        idle(4 * P, "R8");
        rd_reg(5, "R8"); check("R8", bus_rdata, 32'h00);
        rd_reg(4, "R8"); check("R8", bus_rdata, 32'h01);

        // R10 busy window drops time writes
        rd_reg(7, "R10");
        while (bus_rdata[0] !== 1'b1) rd_reg(7, "R10");
        begin
            int keep = m_f[1];
            wr_reg(1, 32'h11, "R10");
            check("R10", bus_rdata, 32'(keep));
        end
        rd_reg(7, "R10");
        while (bus_rdata[0] !== 1'b0) rd_reg(7, "R10");
        wr_reg(1, 32'h22, "R10");
        check("R10", bus_rdata, 32'h22);

        // R6 pause by run bit, oscillator bit and missing enable
        pause_safe("R6");
        begin
            logic [31:0] held;
            rd_reg(0, "R6"); held = bus_rdata;
            idle(5 * P, "R6");
            rd_reg(0, "R6"); check("R6", bus_rdata, held);
            wr_reg(8, 32'd0, "R6");
            wr_reg(6, 32'd1, "R6");
            idle(5 * P, "R6");
            rd_reg(0, "R6"); check("R6", bus_rdata, held);
            tick_on = 0;
            wr_reg(8, 32'd1, "R6");
            idle(5 * P, "R6");
            rd_reg(0, "R6"); check("R6", bus_rdata, held);
            tick_on = 1;
            idle(3 * P, "R6");
            rd_reg(0, "R6");
            checks++;
            if (bus_rdata === held) begin
                errors++;
                $display("FAIL R6 actual %h expected change from %h", bus_rdata, held);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule